// File: doc/BRIEF.md
# Multi-Size Partition Mode Selector

This block scores one buffered 16×16 depth block under three partitionings at once: a single 16×16 unit, four 8×8 units and sixteen 4×4 units. Every unit is predicted with a two-region rule. The unit mean, rounded down, serves as a threshold. Samples strictly above it form the upper region and the rest form the lower region. Each region is then predicted by the floor of its own sample mean. The sum of absolute differences between the original and the prediction is the cost of the unit.

Three predictor lanes, one per unit size, read the same sample buffer concurrently. Each lane walks its units in raster order of their position in the 16×16 block. It accumulates the unit costs into one cost that covers the whole 16×16 area. When all lanes have finished, the cheapest size is selected. The block then reports the selected size, its total cost and a residue read port for that size.

Software writes the 256 samples through the load port, pulses `start` and waits for `done`. It then reads the chosen size, the cost and any residue sample by address.

Top module: `part_size_sel`

## Requirements
- R1: A cycle with `ld_en` high writes `ld_data` into the sample buffer at `ld_addr`. The address is row*16+column of the 16×16 block.
- R2: In every unit the threshold is the floor of the unit's sample mean. A sample belongs to the upper region only when it is strictly greater than that threshold.
- R3: Each region is predicted by the floor of the mean of its own samples. An empty upper region predicts 0, and this value is never applied to any sample.
- R4: All three sizes are evaluated over the same buffered block in the same run. Each size's cost is the sum of the absolute differences between original and prediction over all 256 samples.
- R5: `best_size` reports the size with the smallest cost, coded 0 = 16×16, 1 = 8×8, 2 = 4×4. `best_sad` reports that cost.
- R6: On equal costs the larger unit wins. 16×16 is preferred over 8×8, and 8×8 is preferred over 4×4.
- R7: `res_data` is the 9-bit two's-complement value original minus prediction for the sample at `res_addr`. It uses the size in `best_size` and the same row*16+column addressing.
- R8: A `start` pulse while idle begins an evaluation. `done` is a one-cycle pulse raised only after all three lanes have finished. `best_size` and `best_sad` hold their values until the next `done`.
- R9: A `start` pulse during an evaluation is ignored. The run is not restarted and its completion time does not change.
- R10: After reset `done` is 0, `best_size` is 0 and `best_sad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Sample write enable |
| ld_addr | input | 8 | Sample address, row*16+column |
| ld_data | input | 8 | Sample value |
| start | input | 1 | Begin evaluation of the buffered block |
| done | output | 1 | One-cycle pulse when the selection is ready |
| best_size | output | 2 | Selected size: 0 = 16×16, 1 = 8×8, 2 = 4×4 |
| best_sad | output | 16 | Total cost of the selected size |
| res_addr | input | 8 | Residue read address, row*16+column |
| res_data | output | 9 | Signed residue of the addressed sample |

## Verification
A lane with a wrong threshold or region mean would change only the units it owns. It shows at the ports as a cost that differs from the bench's model. It also shows as residues that are wrong at exactly the addresses of those units, and both are visible on the first `done` after the fault. A lane whose unit or position counter drifts would read the wrong samples, which usually breaks the selection as well. A control fault such as a restart on a second `start` shows as a completion time that differs from a clean run. Blocks chosen so that each size in turn is exact, together with tie cases, expose a wrong tie order or a wrong size code at once.

// File: rtl/psel_pkg.sv
package psel_pkg;
  localparam int NUM_LANES = 3;

  typedef enum logic [1:0] {
    PH_MEAN  = 2'd0,
    PH_SPLIT = 2'd1,
    PH_SAD   = 2'd2
  } phase_e;
endpackage

// File: rtl/psel_lane.sv
module psel_lane
  import psel_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int BLK_LOG = 4,
  parameter int LOG_N   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  output logic [2*BLK_LOG-1:0]       rd_addr_o,
  input  logic [PIX_W-1:0]           rd_pix_i,
  output logic                       done_o,
  output logic [PIX_W+2*BLK_LOG-1:0] cost_o,
  input  logic [2*BLK_LOG-1:0]       q_addr_i,
  input  logic [PIX_W-1:0]           q_pix_i,
  output logic [PIX_W-1:0]           q_pred_o
);
  localparam int AW       = 2 * BLK_LOG;
  localparam int SW       = PIX_W + AW;
  localparam int CW       = AW + 1;
  localparam int N        = 1 << LOG_N;
  localparam int NN       = N * N;
  localparam int GRID_LOG = BLK_LOG - LOG_N;
  localparam int GRID     = 1 << GRID_LOG;
  localparam int NU       = GRID * GRID;
  localparam int UIW      = (NU > 1) ? $clog2(NU) : 1;
  localparam int NUA      = 1 << UIW;

  logic           busy_q, busy_d;
  phase_e         ph_q, ph_d;
  logic [UIW-1:0] u_q, u_d;
  logic [AW-1:0]  p_q, p_d;
  logic [SW-1:0]  acc_q, acc_d, s1_q, s1_d, s0_q, s0_d, cost_q, cost_d;
  logic [CW-1:0]  c1_q, c1_d;
  logic           done_q, done_d;

  logic [PIX_W-1:0] thr_q [NUA];
  logic [PIX_W-1:0] lo_q  [NUA];
  logic [PIX_W-1:0] hi_q  [NUA];

  logic             we_thr, we_cpv;
  logic [PIX_W-1:0] thr_n, lo_n, hi_n, pred, dif;
  logic [SW-1:0]    acc_f, s1_f, s0_f;
  logic [CW-1:0]    c1_f, c0_f;
  logic [AW-1:0]    u_ext, row, col;
  logic             hi_side, last_p, last_u;

  // unit / position to buffer address
  always_comb begin
    u_ext     = AW'(u_q);
    row       = ((u_ext >> GRID_LOG) << LOG_N) + (p_q >> LOG_N);
    col       = ((u_ext & AW'(GRID - 1)) << LOG_N) + (p_q & AW'(N - 1));
    rd_addr_o = (row << BLK_LOG) | col;
    last_p    = (p_q == AW'(NN - 1));
    last_u    = (u_q == UIW'(NU - 1));
  end

  // datapath arithmetic
  always_comb begin
    hi_side = rd_pix_i > thr_q[u_q];
    acc_f   = acc_q + SW'(rd_pix_i);
    s1_f    = hi_side ? s1_q + SW'(rd_pix_i) : s1_q;
    s0_f    = hi_side ? s0_q : s0_q + SW'(rd_pix_i);
    c1_f    = c1_q + CW'(hi_side);
    c0_f    = CW'(NN) - c1_f;
    thr_n   = PIX_W'(acc_f >> (2 * LOG_N));
    hi_n    = (c1_f == '0) ? '0 : PIX_W'(s1_f / SW'(c1_f));
    lo_n    = (c0_f == '0) ? '0 : PIX_W'(s0_f / SW'(c0_f));
    pred    = hi_side ? hi_q[u_q] : lo_q[u_q];
    dif     = (rd_pix_i >= pred) ? rd_pix_i - pred : pred - rd_pix_i;
  end

  // next state
  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    u_d    = u_q;
    p_d    = p_q;
    acc_d  = acc_q;
    s1_d   = s1_q;
    s0_d   = s0_q;
    c1_d   = c1_q;
    cost_d = cost_q;
    done_d = 1'b0;
    we_thr = 1'b0;
    we_cpv = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        ph_d   = PH_MEAN;
        u_d    = '0;
        p_d    = '0;
        acc_d  = '0;
        s1_d   = '0;
        s0_d   = '0;
        c1_d   = '0;
        cost_d = '0;
      end
    end else begin
      p_d = last_p ? '0 : p_q + AW'(1);
      case (ph_q)
        PH_MEAN: begin
          acc_d = acc_f;
          if (last_p) begin
            we_thr = 1'b1;
            acc_d  = '0;
            ph_d   = PH_SPLIT;
          end
        end
        PH_SPLIT: begin
          s1_d = s1_f;
          s0_d = s0_f;
          c1_d = c1_f;
          if (last_p) begin
            we_cpv = 1'b1;
            s1_d   = '0;
            s0_d   = '0;
            c1_d   = '0;
            ph_d   = PH_SAD;
          end
        end
        default: begin
          cost_d = cost_q + SW'(dif);
          if (last_p) begin
            ph_d = PH_MEAN;
            if (last_u) begin
              busy_d = 1'b0;
              done_d = 1'b1;
            end else begin
              u_d = u_q + UIW'(1);
            end
          end
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= PH_MEAN;
      u_q    <= '0;
      p_q    <= '0;
      acc_q  <= '0;
      s1_q   <= '0;
      s0_q   <= '0;
      c1_q   <= '0;
      cost_q <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < NUA; i++) begin
        thr_q[i] <= '0;
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
      end
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      u_q    <= u_d;
      p_q    <= p_d;
      acc_q  <= acc_d;
      s1_q   <= s1_d;
      s0_q   <= s0_d;
      c1_q   <= c1_d;
      cost_q <= cost_d;
      done_q <= done_d;
      if (we_thr) thr_q[u_q] <= thr_n;
      if (we_cpv) begin
        lo_q[u_q] <= lo_n;
        hi_q[u_q] <= hi_n;
      end
    end
  end

  assign done_o = done_q;
  assign cost_o = cost_q;

  // residue query port
  logic [AW-1:0]  qr, qc;
  logic [UIW-1:0] qu;
  always_comb begin
    qr       = q_addr_i >> BLK_LOG;
    qc       = q_addr_i & AW'((1 << BLK_LOG) - 1);
    qu       = UIW'(((qr >> LOG_N) << GRID_LOG) + (qc >> LOG_N));
    q_pred_o = (q_pix_i > thr_q[qu]) ? hi_q[qu] : lo_q[qu];
  end

  // R3
  region_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (lo_q[qu] <= thr_q[qu]));
  // R3
  region_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && hi_q[qu] != '0) |-> (hi_q[qu] > thr_q[qu]));
  // R4
  lane_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && !busy_q));
endmodule

// File: rtl/psel_pick.sv
module psel_pick #(
  parameter int SW = 16
) (
  input  logic [SW-1:0] cost_big_i,
  input  logic [SW-1:0] cost_mid_i,
  input  logic [SW-1:0] cost_small_i,
  output logic [1:0]    size_o,
  output logic [SW-1:0] best_o
);
  always_comb begin
    if (cost_big_i <= cost_mid_i && cost_big_i <= cost_small_i) begin
      size_o = 2'd0;
      best_o = cost_big_i;
    end else if (cost_mid_i <= cost_small_i) begin
      size_o = 2'd1;
      best_o = cost_mid_i;
    end else begin
      size_o = 2'd2;
      best_o = cost_small_i;
    end
  end
endmodule

// File: rtl/part_size_sel.sv
module part_size_sel
  import psel_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int BLK_LOG = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_en,
  input  logic [2*BLK_LOG-1:0]       ld_addr,
  input  logic [PIX_W-1:0]           ld_data,
  input  logic                       start,
  output logic                       done,
  output logic [1:0]                 best_size,
  output logic [PIX_W+2*BLK_LOG-1:0] best_sad,
  input  logic [2*BLK_LOG-1:0]       res_addr,
  output logic [PIX_W:0]             res_data
);
  localparam int AW   = 2 * BLK_LOG;
  localparam int SW   = PIX_W + AW;
  localparam int NPIX = 1 << AW;

  logic [PIX_W-1:0] pix_q [NPIX];

  always_ff @(posedge clk) begin
    if (ld_en) pix_q[ld_addr] <= ld_data;
  end

  logic [AW-1:0]    lane_addr [NUM_LANES];
  logic [PIX_W-1:0] lane_pix  [NUM_LANES];
  logic [SW-1:0]    lane_cost [NUM_LANES];
  logic [PIX_W-1:0] lane_pred [NUM_LANES];
  logic [NUM_LANES-1:0] lane_done;
  logic             start_go;
  logic [PIX_W-1:0] q_pix;

  assign q_pix = pix_q[res_addr];

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    assign lane_pix[k] = pix_q[lane_addr[k]];
    psel_lane #(
      .PIX_W  (PIX_W),
      .BLK_LOG(BLK_LOG),
      .LOG_N  (BLK_LOG - k)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_go),
      .rd_addr_o(lane_addr[k]),
      .rd_pix_i (lane_pix[k]),
      .done_o   (lane_done[k]),
      .cost_o   (lane_cost[k]),
      .q_addr_i (res_addr),
      .q_pix_i  (q_pix),
      .q_pred_o (lane_pred[k])
    );
  end

  logic [1:0]    pick_size;
  logic [SW-1:0] pick_cost;

  psel_pick #(.SW(SW)) u_pick (
    .cost_big_i  (lane_cost[0]),
    .cost_mid_i  (lane_cost[1]),
    .cost_small_i(lane_cost[2]),
    .size_o      (pick_size),
    .best_o      (pick_cost)
  );

  logic                 busy_q, busy_d, done_q, done_d, res_en;
  logic [NUM_LANES-1:0] fin_q, fin_d;
  logic [1:0]           size_q;
  logic [SW-1:0]        sad_q;

  always_comb begin
    start_go = start & ~busy_q;
    busy_d   = busy_q;
    fin_d    = fin_q;
    done_d   = 1'b0;
    res_en   = 1'b0;
    if (start_go) begin
      busy_d = 1'b1;
      fin_d  = '0;
    end else if (busy_q) begin
      fin_d = fin_q | lane_done;
      if (&fin_d) begin
        busy_d = 1'b0;
        fin_d  = '0;
        done_d = 1'b1;
        res_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= '0;
      done_q <= 1'b0;
      size_q <= '0;
      sad_q  <= '0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      done_q <= done_d;
      if (res_en) begin
        size_q <= pick_size;
        sad_q  <= pick_cost;
      end
    end
  end

  logic [PIX_W-1:0] pred_sel;
  always_comb begin
    case (size_q)
      2'd0:    pred_sel = lane_pred[0];
      2'd1:    pred_sel = lane_pred[1];
      default: pred_sel = lane_pred[2];
    endcase
    res_data = {1'b0, q_pix} - {1'b0, pred_sel};
  end

  assign done      = done_q;
  assign best_size = size_q;
  assign best_sad  = sad_q;

  // R5
  min_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (best_sad <= lane_cost[0] && best_sad <= lane_cost[1] && best_sad <= lane_cost[2]));
  // R6
  tie_pref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lane_cost[0] == best_sad) |-> best_size == 2'd0);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_size != 2'd3);
endmodule

// File: tb/sim_part_size_sel.sv
module sim_part_size_sel;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_en, start;
  logic [7:0] ld_addr, ld_data, res_addr;
  logic       done;
  logic [1:0] best_size;
  logic [15:0] best_sad;
  logic [8:0] res_data;

  always #5 clk = ~clk;

  part_size_sel u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .start(start), .done(done), .best_size(best_size), .best_sad(best_sad),
    .res_addr(res_addr), .res_data(res_data)
  );

  int checks = 0;
  int errors = 0;
  int blk [256];
  int epred [3][256];
  int ecost [3];
  int esize, esad;
  int lat0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent reference of the two-region rule for every size
  task automatic model();
    for (int sz = 0; sz < 3; sz++) begin
      int n, grid;
      n = 16 >> sz;
      grid = 16 / n;
      ecost[sz] = 0;
      for (int uy = 0; uy < grid; uy++) begin
        for (int ux = 0; ux < grid; ux++) begin
          int sum, mean, s1, c1, s0, c0, h, l;
          sum = 0; s1 = 0; c1 = 0; s0 = 0; c0 = 0;
          for (int y = 0; y < n; y++)
            for (int x = 0; x < n; x++) sum += blk[(uy*n+y)*16 + ux*n+x];
          mean = sum / (n*n);
          for (int y = 0; y < n; y++)
            for (int x = 0; x < n; x++) begin
              int v;
              v = blk[(uy*n+y)*16 + ux*n+x];
              if (v > mean) begin s1 += v; c1++; end
              else begin s0 += v; c0++; end
            end
          h = (c1 == 0) ? 0 : s1 / c1;
          l = (c0 == 0) ? 0 : s0 / c0;
          for (int y = 0; y < n; y++)
            for (int x = 0; x < n; x++) begin
              int a, v, pr;
              a = (uy*n+y)*16 + ux*n+x;
              v = blk[a];
              pr = (v > mean) ? h : l;
              epred[sz][a] = pr;
              ecost[sz] += (v > pr) ? v - pr : pr - v;
            end
        end
      end
    end
    if (ecost[0] <= ecost[1] && ecost[0] <= ecost[2]) esize = 0;
    else if (ecost[1] <= ecost[2]) esize = 1;
    else esize = 2;
    esad = ecost[esize];
  endtask

  task automatic load_block();
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(a); ld_data = 8'(blk[a]);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(input int extra_at, output int lat);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 1;
    while (!done && lat < 4000) begin
      if (lat == extra_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk(done == 1'b1, "R8 done arrives", int'(done), 1);
  endtask

  task automatic verify(input string tag);
    int bad, first_a, act, exp;
    chk(best_size == 2'(esize), {tag, " R5 size"}, int'(best_size), esize);
    chk(best_sad == 16'(esad), {tag, " R4 cost"}, int'(best_sad), esad);
    bad = 0; first_a = -1; act = 0; exp = 0;
    for (int a = 0; a < 256; a++) begin
      int r, e;
      res_addr = 8'(a);
      #1;
      r = int'($signed(res_data));
      e = blk[a] - epred[esize][a];
      if (r != e) begin
        if (bad == 0) begin first_a = a; act = r; exp = e; end
        bad++;
      end
    end
    chk(bad == 0, {tag, " R7 residue (first bad addr shown in values)"}, act, exp);
    if (bad != 0) $display("  residue mismatches %0d, first at %0d", bad, first_a);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R10 done after reset", int'(done), 0);
    chk(best_size == 2'd0, "R10 size after reset", int'(best_size), 0);
    chk(best_sad == 16'd0, "R10 cost after reset", int'(best_sad), 0);
  endtask

  task automatic t_uniform();
    int lat;
    for (int a = 0; a < 256; a++) blk[a] = 77;
    model(); load_block(); run(-1, lat);
    lat0 = lat;
    chk(best_sad == 16'd0, "R1 R3 uniform cost zero", int'(best_sad), 0);
    verify("uniform");
  endtask

  task automatic t_vedge();
    int lat;
    for (int a = 0; a < 256; a++) blk[a] = ((a % 16) < 5) ? 30 : 200;
    model(); load_block(); run(-1, lat);
    chk(best_size == 2'd0, "R6 vertical edge tie keeps 16x16", int'(best_size), 0);
    verify("vedge");
  endtask

  task automatic t_quads();
    int lat;
    for (int a = 0; a < 256; a++) begin
      int r, c, lr, lc, q;
      r = a / 16; c = a % 16; lr = r % 8; lc = c % 8; q = (r / 8) * 2 + (c / 8);
      case (q)
        0: blk[a] = (lc < 3) ? 10 : 60;
        1: blk[a] = (lr < 5) ? 100 : 180;
        2: blk[a] = (lr > lc) ? 20 : 250;
        default: blk[a] = 140;
      endcase
    end
    model(); load_block(); run(-1, lat);
    chk(best_size == 2'd1, "R6 quadrants tie picks 8x8 over 4x4", int'(best_size), 1);
    verify("quads");
  endtask

  task automatic t_small();
    int lat;
    for (int a = 0; a < 256; a++) begin
      int r, c;
      r = a / 16; c = a % 16;
      blk[a] = ((r / 4) * 4 + (c / 4)) * 13 + (((c % 4) < 2) ? 0 : 5);
    end
    model(); load_block(); run(-1, lat);
    chk(best_size == 2'd2, "R5 4x4 wins", int'(best_size), 2);
    verify("small");
  endtask

  task automatic t_random(input int seed);
    int x, lat;
    x = seed;
    for (int a = 0; a < 256; a++) begin
      x = x * 1103515245 + 12345;
      blk[a] = (x >>> 16) & 255;
    end
    model(); load_block(); run(-1, lat);
    chk(lat == lat0, "R4 lanes finish together in fixed time", lat, lat0);
    verify("random R2");
  endtask

  task automatic t_busy_start();
    int lat;
    logic [1:0] s0;
    logic [15:0] c0;
    for (int a = 0; a < 256; a++) blk[a] = (a * 37 + (a / 16) * 11) % 256;
    model(); load_block(); run(100, lat);
    chk(lat == lat0, "R9 start during run ignored", lat, lat0);
    verify("busy");
    s0 = best_size; c0 = best_sad;
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(done == 1'b0, "R8 done is a single pulse", int'(done), 0);
    chk(best_size == s0 && best_sad == c0, "R8 results held", int'(best_sad), int'(c0));
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; start = 1'b0;
    ld_addr = '0; ld_data = '0; res_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_uniform();
    t_vedge();
    t_quads();
    t_small();
    t_random(12345);
    t_random(987);
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule